// File: doc/BRIEF.md
# Multi-Port Register File with Selectable Read Behaviour

This block is a register file with a configurable number of write ports and read ports, a configurable word width and a configurable depth. All storage is made of simple banks, each with one write port and one read port. There is one bank for every pairing of a write port and a read port. Write port `w` writes every bank in its row. Each read port can therefore see one bank per writer. A small live-value table records, for every entry, which writer stored to it last. Each read port uses that record to pick the bank that holds the current value.

An elaboration-time parameter sets how the read ports behave when a read and a write happen in the same cycle. The four choices are:
- a purely combinational read;
- a clocked read that returns the contents from before the write;
- a clocked read that returns the newly written word;
- a read-through mode, in which only the address is registered and the array is read combinationally at that held address.

With no parameters given, the block has one write port, two read ports and combinational reads.

Before its first write, every entry reads as zero. The storage arrays have no reset and no initial contents. Instead, a per-entry written flag in the live-value table is cleared by reset and masks the output. Reset also clears the registered read state.

Top module: `lvt_regfile`

## Requirements
- R1: After reset, every read port returns zero for every entry that has not been written since that reset, in every read mode.
- R2: A word written through any write port is stored, and any read port can read it back until another write to that entry replaces it.
- R3: When several write ports write the same entry on the same clock edge, the highest-numbered of those ports decides the stored word.
- R4: READ_MODE 0 (combinational) drives `rd_data` combinationally from `rd_addr`. A write becomes visible only after the clock edge that performs it.
- R5: READ_MODE 1 (old data) captures the word at `rd_addr` on a clock edge where `rd_en` is high. A write to that entry on the same edge does not affect the captured word.
- R6: READ_MODE 2 (new data) captures the word at `rd_addr` on a clock edge where `rd_en` is high. A write to that entry on the same edge is included, and the R3 rule applies when several ports collide.
- R7: READ_MODE 3 (read-through) registers `rd_addr` on a clock edge where `rd_en` is high. `rd_data` then shows the array contents at the held address, including writes made after the address was captured.
- R8: When `rd_en` of a port is low, modes 1 and 2 keep their output word and mode 3 keeps its held address. Mode 0 ignores `rd_en`.
- R9: Asserting `rst_n` low after entries have been written makes every entry read as zero again, and clears all registered read outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| wr_en | input | NUM_WR | Write enable, bit `w` for write port `w` |
| wr_addr | input | NUM_WR*AW | Write addresses; port `w` uses bits `[w*AW +: AW]`, with AW = clog2(DEPTH) |
| wr_data | input | NUM_WR*DATA_W | Write data; port `w` uses bits `[w*DATA_W +: DATA_W]` |
| rd_en | input | NUM_RD | Read capture enable per read port (modes 1 to 3) |
| rd_addr | input | NUM_RD*AW | Read addresses; port `p` uses bits `[p*AW +: AW]` |
| rd_data | output | NUM_RD*DATA_W | Read data; port `p` uses bits `[p*DATA_W +: DATA_W]` |

## Verification
The bench builds four copies of the block: three write ports, two read ports, 16-bit words and 16 entries, one copy in each read mode. All four copies are driven by the same stimulus, so a single write/read sequence shows how the four modes differ on the same cycle. Three writers give a two-bit live-value select with one code that is never used. They also allow three-way and two-way collisions on one entry. Sixteen entries let a sweep touch every address, and let a reset after those writes show that every entry reads zero again.

// File: rtl/lvtrf_pkg.sv
package lvtrf_pkg;

  // Read-during-write behaviour of every read port.
  typedef enum logic [1:0] {
    RM_ASYNC       = 2'd0,
    RM_READ_FIRST  = 2'd1,
    RM_WRITE_FIRST = 2'd2,
    RM_THROUGH     = 2'd3
  } rmode_e;

  // Width of a writer index; at least one bit so that vectors never collapse.
  function automatic int unsigned sel_width(input int unsigned n_wr);
    return (n_wr > 1) ? $clog2(n_wr) : 1;
  endfunction

endpackage

// File: rtl/rf_bank.sv
// One-write, one-read storage bank. The storage is not reset; the live-value
// table masks entries that have not been written.
module rf_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned AW     = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/rf_live_table.sv
// Per-entry record of the last writer and a written flag.
module rf_live_table #(
  parameter int unsigned NUM_WR = 1,
  parameter int unsigned NUM_RD = 2,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned AW     = 5,
  parameter int unsigned SW     = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WR-1:0]    wr_en,
  input  logic [NUM_WR*AW-1:0] wr_addr,
  input  logic [NUM_RD*AW-1:0] rd_addr,
  output logic [NUM_RD*SW-1:0] rd_sel,
  output logic [NUM_RD-1:0]    rd_valid
);

  logic [SW-1:0]    sel_q [DEPTH];
  logic [SW-1:0]    sel_d [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;

  // Next state: ascending port order, so a higher port overrides a lower one.
  always_comb begin
    sel_d = sel_q;
    vld_d = vld_q;
    for (int w = 0; w < int'(NUM_WR); w++) begin
      if (wr_en[w]) begin
        sel_d[wr_addr[w*AW +: AW]] = SW'(w);
        vld_d[wr_addr[w*AW +: AW]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        sel_q[i] <= '0;
      end
      vld_q <= '0;
    end else begin
      sel_q <= sel_d;
      vld_q <= vld_d;
    end
  end

  for (genvar p = 0; p < int'(NUM_RD); p++) begin : g_rd
    assign rd_sel[p*SW +: SW] = sel_q[rd_addr[p*AW +: AW]];
    assign rd_valid[p]        = vld_q[rd_addr[p*AW +: AW]];
  end

  // R2: once written, an entry stays written until reset.
  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_sticky
    assert_entry_stays_written_R2: assert property (
      @(posedge clk) disable iff (!rst_n) vld_q[i] |=> vld_q[i]);
  end

  // R3: the highest-numbered writer always owns its entry after the edge.
  if (NUM_WR > 1) begin : g_prio
    assert_top_writer_wins_R3: assert property (
      @(posedge clk) disable iff (!rst_n)
      wr_en[NUM_WR-1] |=>
        (sel_q[$past(wr_addr[(NUM_WR-1)*AW +: AW])] == SW'(NUM_WR-1)) &&
        vld_q[$past(wr_addr[(NUM_WR-1)*AW +: AW])]);
  end

endmodule

// File: rtl/rf_read_port.sv
// One read port: picks the live bank and applies the selected read mode.
module rf_read_port
  import lvtrf_pkg::*;
#(
  parameter int unsigned NUM_WR    = 1,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned AW        = 5,
  parameter int unsigned SW        = 1,
  parameter rmode_e      READ_MODE = RM_ASYNC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  output logic [AW-1:0]            addr_eff,
  input  logic [NUM_WR*DATA_W-1:0] bank_data,
  input  logic [SW-1:0]            lvt_sel,
  input  logic                     lvt_valid,
  input  logic [NUM_WR-1:0]        wr_en,
  input  logic [NUM_WR*AW-1:0]     wr_addr,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0]        rd_data
);

  localparam bit IS_WF = (READ_MODE == RM_WRITE_FIRST);

  logic unused_inputs;
  assign unused_inputs = ^{rd_en, wr_en, wr_addr, wr_data};

  if (READ_MODE == RM_ASYNC || READ_MODE == RM_THROUGH) begin : g_comb

    logic [DATA_W-1:0] live;

    if (READ_MODE == RM_THROUGH) begin : g_hold_addr
      logic [AW-1:0] addr_q;
      logic [AW-1:0] addr_d;

      always_comb begin
        addr_d = addr_q;
        if (rd_en) begin
          addr_d = rd_addr;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          addr_q <= '0;
        end else begin
          addr_q <= addr_d;
        end
      end

      assign addr_eff = addr_q;

      // R8: a disabled port keeps its captured address.
      assert_through_addr_held_R8: assert property (
        @(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(addr_eff));
    end else begin : g_direct
      assign addr_eff = rd_addr;
    end

    always_comb begin
      live = '0;
      for (int w = 0; w < int'(NUM_WR); w++) begin
        if (lvt_sel == SW'(w)) begin
          live = bank_data[w*DATA_W +: DATA_W];
        end
      end
      rd_data = lvt_valid ? live : '0;
    end

  end else begin : g_clocked

    logic [DATA_W-1:0] cap_q [NUM_WR];
    logic [DATA_W-1:0] cap_d [NUM_WR];
    logic [SW-1:0]     sel_q;
    logic [SW-1:0]     sel_d;
    logic              vld_q;
    logic              vld_d;
    logic              hit_any;
    logic [SW-1:0]     hit_sel;

    assign addr_eff = rd_addr;

    // Next state: bank words plus select, delayed together by one edge.
    always_comb begin
      hit_any = 1'b0;
      hit_sel = '0;
      for (int w = 0; w < int'(NUM_WR); w++) begin
        cap_d[w] = cap_q[w];
        if (rd_en) begin
          cap_d[w] = bank_data[w*DATA_W +: DATA_W];
          if (IS_WF && wr_en[w] && (wr_addr[w*AW +: AW] == rd_addr)) begin
            cap_d[w] = wr_data[w*DATA_W +: DATA_W];
            hit_any  = 1'b1;
            hit_sel  = SW'(w);
          end
        end
      end
      sel_d = sel_q;
      vld_d = vld_q;
      if (rd_en) begin
        sel_d = hit_any ? hit_sel : lvt_sel;
        vld_d = lvt_valid | hit_any;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < int'(NUM_WR); w++) begin
          cap_q[w] <= '0;
        end
        sel_q <= '0;
        vld_q <= 1'b0;
      end else begin
        cap_q <= cap_d;
        sel_q <= sel_d;
        vld_q <= vld_d;
      end
    end

    always_comb begin
      rd_data = '0;
      for (int w = 0; w < int'(NUM_WR); w++) begin
        if (vld_q && (sel_q == SW'(w))) begin
          rd_data = cap_q[w];
        end
      end
    end

    // R8: a disabled port keeps its output word.
    assert_clocked_data_held_R8: assert property (
      @(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rd_data));

    if (IS_WF) begin : g_wf_chk
      // R6: a same-edge write by the top writer is returned.
      assert_new_data_returned_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        rd_en && wr_en[NUM_WR-1] && (wr_addr[(NUM_WR-1)*AW +: AW] == rd_addr)
        |=> rd_data == $past(wr_data[(NUM_WR-1)*DATA_W +: DATA_W]));
    end else begin : g_rf_chk
      // R5: an entry never written before the edge reads old contents, zero.
      assert_old_data_unwritten_zero_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        rd_en && !lvt_valid |=> rd_data == '0);
    end

  end

endmodule

// File: rtl/lvt_regfile.sv
// Multi-port register file built from replicated 1W1R banks and a
// live-value table. rst_n is expected to be released synchronously.
module lvt_regfile
  import lvtrf_pkg::*;
#(
  parameter int unsigned NUM_WR    = 1,
  parameter int unsigned NUM_RD    = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 32,
  parameter rmode_e      READ_MODE = RM_ASYNC,
  localparam int unsigned AW       = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WR-1:0]        wr_en,
  input  logic [NUM_WR*AW-1:0]     wr_addr,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  input  logic [NUM_RD-1:0]        rd_en,
  input  logic [NUM_RD*AW-1:0]     rd_addr,
  output logic [NUM_RD*DATA_W-1:0] rd_data
);

  localparam int unsigned SW     = sel_width(NUM_WR);
  localparam int unsigned ROW_W  = NUM_WR * DATA_W;

  logic [NUM_RD*AW-1:0]    addr_eff;
  logic [NUM_RD*SW-1:0]    lvt_sel;
  logic [NUM_RD-1:0]       lvt_vld;
  logic [NUM_RD*ROW_W-1:0] bank_rd;

  rf_live_table #(
    .NUM_WR (NUM_WR),
    .NUM_RD (NUM_RD),
    .DEPTH  (DEPTH),
    .AW     (AW),
    .SW     (SW)
  ) i_live_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (addr_eff),
    .rd_sel   (lvt_sel),
    .rd_valid (lvt_vld)
  );

  for (genvar p = 0; p < int'(NUM_RD); p++) begin : g_rport
    for (genvar w = 0; w < int'(NUM_WR); w++) begin : g_bank
      rf_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
      ) i_bank (
        .clk   (clk),
        .we    (wr_en[w]),
        .waddr (wr_addr[w*AW +: AW]),
        .wdata (wr_data[w*DATA_W +: DATA_W]),
        .raddr (addr_eff[p*AW +: AW]),
        .rdata (bank_rd[p*ROW_W + w*DATA_W +: DATA_W])
      );
    end

    rf_read_port #(
      .NUM_WR    (NUM_WR),
      .DATA_W    (DATA_W),
      .AW        (AW),
      .SW        (SW),
      .READ_MODE (READ_MODE)
    ) i_read_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en[p]),
      .rd_addr   (rd_addr[p*AW +: AW]),
      .addr_eff  (addr_eff[p*AW +: AW]),
      .bank_data (bank_rd[p*ROW_W +: ROW_W]),
      .lvt_sel   (lvt_sel[p*SW +: SW]),
      .lvt_valid (lvt_vld[p]),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_data   (rd_data[p*DATA_W +: DATA_W])
    );
  end

endmodule

// File: tb/test_lvt_regfile.sv
module test_lvt_regfile;

  localparam int PERIOD = 10;
  localparam int NW = 3;
  localparam int NR = 2;
  localparam int DW = 16;
  localparam int DP = 16;
  localparam int AW = 4;

  logic clk;
  logic rst_n;
  logic [NW-1:0]    wr_en;
  logic [NW*AW-1:0] wr_addr;
  logic [NW*DW-1:0] wr_data;
  logic [NR-1:0]    rd_en;
  logic [NR*AW-1:0] rd_addr;
  logic [NR*DW-1:0] rd_all [4];

  for (genvar m = 0; m < 4; m++) begin : g_mode
    lvt_regfile #(
      .NUM_WR    (NW),
      .NUM_RD    (NR),
      .DATA_W    (DW),
      .DEPTH     (DP),
      .READ_MODE (lvtrf_pkg::rmode_e'(m))
    ) i_lvt_regfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_all[m])
    );
  end

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    int          mode;
    int          port;
    logic [DW-1:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Stimulus staging and reference state
  logic          s_we [NW];
  logic [AW-1:0] s_wa [NW];
  logic [DW-1:0] s_wd [NW];
  logic          s_re [NR];
  logic [AW-1:0] s_ra [NR];
  logic [DW-1:0] model [DP];
  logic [DW-1:0] h_rf [NR];
  logic [DW-1:0] h_wf [NR];
  logic [AW-1:0] h_rt [NR];

  function automatic string mode_req(input int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic clr();
    for (int w = 0; w < NW; w++) begin
      s_we[w] = 1'b0; s_wa[w] = '0; s_wd[w] = '0;
    end
    for (int p = 0; p < NR; p++) begin
      s_re[p] = 1'b0; s_ra[p] = '0;
    end
  endtask

  task automatic wr(input int w, input int a, input logic [DW-1:0] d);
    s_we[w] = 1'b1; s_wa[w] = AW'(a); s_wd[w] = d;
  endtask

  task automatic rd(input int p, input int a, input logic en);
    s_re[p] = en; s_ra[p] = AW'(a);
  endtask

  task automatic push(input int due, input int m, input int p,
                      input logic [DW-1:0] e, input string req);
    item_t it;
    it.due = due; it.mode = m; it.port = p; it.exp = e;
    it.req = {mode_req(m), " ", req};
    q.push_back(it);
  endtask

  // Driver: applies one cycle of stimulus and queues what each mode must show.
  task automatic go(input string req);
    logic [DW-1:0] nxt [DP];
    int k;
    @(negedge clk);
    for (int w = 0; w < NW; w++) begin
      wr_en[w] = s_we[w];
      wr_addr[w*AW +: AW] = s_wa[w];
      wr_data[w*DW +: DW] = s_wd[w];
    end
    for (int p = 0; p < NR; p++) begin
      rd_en[p] = s_re[p];
      rd_addr[p*AW +: AW] = s_ra[p];
    end
    k = cyc;
    nxt = model;
    for (int w = 0; w < NW; w++) if (s_we[w]) nxt[s_wa[w]] = s_wd[w];
    for (int p = 0; p < NR; p++) push(k, 0, p, model[s_ra[p]], req);
    for (int p = 0; p < NR; p++) begin
      if (s_re[p]) begin
        h_rf[p] = model[s_ra[p]];
        h_wf[p] = nxt[s_ra[p]];
        h_rt[p] = s_ra[p];
      end
    end
    model = nxt;
    for (int p = 0; p < NR; p++) begin
      push(k + 1, 1, p, h_rf[p], req);
      push(k + 1, 2, p, h_wf[p], req);
      push(k + 1, 3, p, model[h_rt[p]], req);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
    q.delete();
    for (int i = 0; i < DP; i++) model[i] = '0;
    for (int p = 0; p < NR; p++) begin
      h_rf[p] = '0; h_wf[p] = '0; h_rt[p] = '0;
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compares each output shortly before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/2 - 2);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [DW-1:0] got;
        it = q.pop_front();
        got = rd_all[it.mode][it.port*DW +: DW];
        n_tests++;
        if (it.due != cyc || got !== it.exp) begin
          n_fail++;
          $display("FAIL %s mode=%0d port=%0d got=%h exp=%h", it.req,
                   it.mode, it.port, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
    clr();
    do_reset();

    // R1: nothing written yet
    clr(); rd(0, 3, 1); rd(1, 7, 1); go("R1 fresh");
    clr(); rd(0, 0, 1); rd(1, 15, 1); go("R1 fresh");

    // R2: each writer to its own entry, read in the same cycle
    clr(); wr(0, 1, 16'h1111); wr(1, 2, 16'h2222); wr(2, 3, 16'h3333);
    rd(0, 1, 1); rd(1, 3, 1); go("R2 write");
    clr(); rd(0, 2, 1); rd(1, 1, 1); go("R2 readback");

    // R3: three-way collision on entry 5
    clr(); wr(0, 5, 16'hAAAA); wr(1, 5, 16'hBBBB); wr(2, 5, 16'hCCCC);
    rd(0, 5, 1); rd(1, 5, 1); go("R3 collide3");
    clr(); rd(0, 5, 1); rd(1, 5, 1); go("R3 R2 after");

    // R3: two-way collision, port 1 must win over port 0
    clr(); wr(0, 6, 16'h0606); wr(1, 6, 16'h1616);
    rd(0, 6, 1); rd(1, 4, 1); go("R3 collide2");
    clr(); rd(0, 6, 1); rd(1, 6, 1); go("R3 R2 after2");

    // R5/R6: overwrite of a written entry while reading it
    clr(); wr(2, 1, 16'h4444); rd(0, 1, 1); rd(1, 1, 1); go("R5 R6 overwrite");

    // R7/R8: capture then write behind a held address
    clr(); rd(0, 2, 1); rd(1, 3, 1); go("R7 capture");
    clr(); wr(0, 2, 16'h5555); rd(0, 9, 0); rd(1, 10, 0); go("R7 R8 hold");
    clr(); wr(1, 3, 16'h7777); rd(0, 11, 0); rd(1, 12, 0); go("R7 R8 hold2");
    clr(); rd(0, 3, 1); rd(1, 2, 1); go("R8 reenable");

    // R2/R4: rotating writers across every entry
    for (int i = 0; i < DP; i++) begin
      clr();
      wr(i % NW, i, DW'(16'hA000 + i * 7));
      rd(0, (i + 15) % DP, logic'(i % 2));
      rd(1, i, 1'b1);
      go("R2 R4 sweep");
    end
    clr(); rd(0, 14, 1); rd(1, 9, 1); go("R2 sweep tail");

    // R9: reset after writes clears everything
    do_reset();
    clr(); rd(0, 1, 0); rd(1, 5, 0); go("R9 R1 after reset");
    clr(); rd(0, 6, 1); rd(1, 3, 1); go("R9 R1 after reset");
    clr(); wr(0, 6, 16'h0BAD); rd(0, 6, 1); rd(1, 2, 1); go("R9 R2 rewrite");
    clr(); go("idle");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule